// File: doc/BRIEF.md
# Event-Triggered SPI ADC Sample Capture

This block reads 16-bit conversion results from an external ADC without any software start. The ADC raises an event flag when its detector fires and holds it high until the result has been clocked out. The block synchronises that flag, runs one SPI read (mode 0, MSB first), and stores the word. Storage is either a small FIFO or a single holding register; a parameter chooses which.

A host collects samples by polling a Wishbone-style slave that has two registers. Address 0 returns the oldest stored sample and removes it. Address 1 holds the status: empty, full and a sticky overflow flag. No interrupt is produced. The SPI clock is divided down from the system clock. With the default settings at 200 MHz, the time from flag to stored sample is well under one microsecond, so the block can keep up with an ADC that must be emptied once per microsecond.

Top module: `evt_adc_capture`

## Requirements
- R1: The event flag passes through two flip-flops. A transfer starts only when the synchronised flag is high, no transfer is running, and the synchronised flag has been seen low since the previous transfer started (out of reset the block is armed).
- R2: The SPI link runs in mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_cs_n` stays low for exactly 16 rising `spi_sclk` edges. `spi_miso` is sampled on each rising edge, MSB first. Each `spi_sclk` half period lasts `CLK_DIV` system clocks.
- R3: With the default parameters, a transfer is complete (chip select high again) fewer than 200 system clocks (1 us at 200 MHz) after the flag rises.
- R4: Samples are stored in arrival order, up to `FIFO_DEPTH` words when `USE_FIFO`=1, or one word when `USE_FIFO`=0. The store is never reported as empty and full at the same time.
- R5: The status register is at address 1. Bit 0 is empty, bit 1 is full and bit 2 is overflow. All other bits read zero.
- R6: A sample that completes while the store is full is dropped and sets overflow (bit 2). Overflow then stays set until a write to address 1 with bit 2 = 1. A write with bit 2 = 0 leaves it unchanged.
- R7: A read of address 0 returns the oldest sample in bits 15:0, with bits 31:16 zero, and removes that sample.
- R8: A read of address 0 while the store is empty returns zero and leaves the status unchanged.
- R9: `wb_ack` rises in the clock cycle after a request is presented and lasts one cycle. Writes to address 0 have no effect.
- R10: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and the status reads 1 (empty, not full, no overflow).
- R11: Each assertion of the flag causes exactly one transfer, even if the flag stays high for some time after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_evt | input | 1 | Asynchronous event flag from the ADC |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | ADC chip select, active low |
| spi_miso | input | 1 | Serial data from the ADC |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | 2 | Register address: 0 data, 1 status |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack | output | 1 | Single-cycle acknowledge |

## Verification
A wrong store pointer or count shows up on the next data read as a sample out of sequence, or as a status word with the wrong empty/full bits. A wrong bit counter in the SPI engine shows up within one transfer: the number of rising clock edges inside chip select changes and the captured word is shifted. A re-arm fault shows up at the next long-held flag as an extra transfer and an extra stored sample. The overflow path can only be seen after the store is filled, and then on the very next status read.

// File: rtl/evcap_pkg.sv
// Shared constants for the event-triggered ADC capture block.
// Assumes a 2-bit register address and a 32-bit bus data path.
package evcap_pkg;
    localparam int BUS_W      = 32;
    localparam logic [1:0] ADR_DATA   = 2'd0;
    localparam logic [1:0] ADR_STATUS = 2'd1;
    localparam int ST_EMPTY_BIT = 0;
    localparam int ST_FULL_BIT  = 1;
    localparam int ST_OVF_BIT   = 2;

    typedef enum logic [0:0] {
        SPI_IDLE  = 1'b0,
        SPI_SHIFT = 1'b1
    } spi_state_t;
endpackage

// File: rtl/evcap_sync.sv
// Multi-stage synchroniser for one asynchronous level input.
// Assumes the input is a slowly changing level (an event flag).
module evcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/evcap_spi_rx.sv
// Mode-0 SPI read engine: on start, drops chip select and clocks in
// WORD_W bits, MSB first, each sampled on a rising SCLK. Each SCLK half
// period is CLK_DIV system clocks. Raises done for one cycle with the word.
// Assumes miso is stable around the rising SCLK (the ADC changes it after).
module evcap_spi_rx #(
    parameter int WORD_W  = 16,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    import evcap_pkg::*;

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = $clog2(WORD_W + 1);

    spi_state_t        state_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  bits_q;
    logic [WORD_W-1:0] shift_q;

    // Sequence chip select, SCLK toggles and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SPI_IDLE;
            div_q   <= '0;
            bits_q  <= '0;
            shift_q <= '0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SPI_IDLE: begin
                    if (start) begin
                        state_q <= SPI_SHIFT;
                        cs_n    <= 1'b0;
                        sclk    <= 1'b0;
                        div_q   <= '0;
                        bits_q  <= '0;
                    end
                end
                default: begin
                    if (div_q == DIV_W'(CLK_DIV - 1)) begin
                        div_q <= '0;
                        if (!sclk) begin
                            sclk    <= 1'b1;
                            shift_q <= {shift_q[WORD_W-2:0], miso};
                            bits_q  <= bits_q + 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bits_q == CNT_W'(WORD_W)) begin
                                cs_n    <= 1'b1;
                                state_q <= SPI_IDLE;
                                done    <= 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state_q != SPI_IDLE);
    assign word = shift_q;
endmodule

// File: rtl/evcap_store.sv
// Sample store: a circular FIFO of DEPTH words when USE_FIFO is 1,
// otherwise one holding register. A push while full is ignored and a
// pop while empty is ignored; the caller reports overflow.
module evcap_store #(
    parameter int WORD_W   = 16,
    parameter int DEPTH    = 4,
    parameter bit USE_FIFO = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic              empty,
    output logic              full
);
    generate
        if (USE_FIFO) begin : g_fifo
            localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam int CNT_W = $clog2(DEPTH + 1);

            logic [WORD_W-1:0] mem_q [DEPTH];
            logic [PTR_W-1:0]  wr_q, rd_q;
            logic [CNT_W-1:0]  cnt_q;
            logic              do_push, do_pop;

            assign do_push = push && !full;
            assign do_pop  = pop && !empty;

            // Write the incoming word into the slot at the write pointer.
            always_ff @(posedge clk) begin
                if (do_push) mem_q[wr_q] <= push_word;
            end

            // Advance the pointers and keep the occupancy count.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_q  <= '0;
                    rd_q  <= '0;
                    cnt_q <= '0;
                end else begin
                    if (do_push)
                        wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
                    if (do_pop)
                        rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
                    if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
                    else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
                end
            end

            assign head_word = mem_q[rd_q];
            assign empty     = (cnt_q == '0);
            assign full      = (cnt_q == CNT_W'(DEPTH));
        end else begin : g_hold
            logic [WORD_W-1:0] hold_q;
            logic              valid_q;

            // Keep one word; a pop frees it, a push fills it when free.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q  <= '0;
                    valid_q <= 1'b0;
                end else if (push && !valid_q) begin
                    hold_q  <= push_word;
                    valid_q <= 1'b1;
                end else if (pop) begin
                    valid_q <= 1'b0;
                end
            end

            assign head_word = hold_q;
            assign empty     = !valid_q;
            assign full      = valid_q;
        end
    endgenerate
endmodule

// File: rtl/evt_adc_capture.sv
// Event-triggered ADC capture: synchronises the ADC event flag, runs one
// SPI read per flag assertion, buffers the word and serves it through a
// polled Wishbone-style slave (address 0 data/pop, address 1 status).
// Assumes the ADC releases its flag once a read has completed.
module evt_adc_capture #(
    parameter int WORD_W     = 16,
    parameter int CLK_DIV    = 2,
    parameter int FIFO_DEPTH = 4,
    parameter bit USE_FIFO   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adc_evt,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    input  logic        spi_miso,
    input  logic        wb_cyc,
    input  logic        wb_stb,
    input  logic        wb_we,
    input  logic [1:0]  wb_adr,
    input  logic [31:0] wb_dat_i,
    output logic [31:0] wb_dat_o,
    output logic        wb_ack
);
    import evcap_pkg::*;

    logic              flag_s;
    logic              armed_q;
    logic              xfer_start;
    logic              xfer_busy;
    logic              xfer_done;
    logic [WORD_W-1:0] xfer_word;
    logic [WORD_W-1:0] head_word;
    logic              st_empty, st_full;
    logic              ovf_q;
    logic              bus_req, rd_data, wr_status;

    evcap_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(adc_evt), .sync_out(flag_s)
    );

    assign xfer_start = flag_s && armed_q && !xfer_busy;

    // Re-arm only once the synchronised flag has been seen low.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b1;
        else if (xfer_start) armed_q <= 1'b0;
        else if (!flag_s)    armed_q <= 1'b1;
    end

    evcap_spi_rx #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) spi_i (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .miso(spi_miso),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .busy(xfer_busy),
        .done(xfer_done), .word(xfer_word)
    );

    assign bus_req   = wb_cyc && wb_stb && !wb_ack;
    assign rd_data   = bus_req && !wb_we && (wb_adr == ADR_DATA);
    assign wr_status = bus_req && wb_we && (wb_adr == ADR_STATUS);

    evcap_store #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .USE_FIFO(USE_FIFO)) store_i (
        .clk(clk), .rst_n(rst_n), .push(xfer_done), .push_word(xfer_word),
        .pop(rd_data), .head_word(head_word), .empty(st_empty), .full(st_full)
    );

    // Sticky overflow: set on a dropped sample, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf_q <= 1'b0;
        else if (xfer_done && st_full)           ovf_q <= 1'b1;
        else if (wr_status && wb_dat_i[ST_OVF_BIT]) ovf_q <= 1'b0;
    end

    // Register the acknowledge and the read data for each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack   <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack   <= bus_req;
            wb_dat_o <= '0;
            if (bus_req && !wb_we) begin
                if (wb_adr == ADR_DATA && !st_empty)
                    wb_dat_o <= BUS_W'(head_word);
                else if (wb_adr == ADR_STATUS)
                    wb_dat_o <= BUS_W'({ovf_q, st_full, st_empty});
            end
        end
    end
endmodule

// File: rtl/evcap_checker.sv
// Property checker for evt_adc_capture, attached by bind below.
// Watches SPI framing, store flags, overflow stickiness and bus timing.
module evcap_checker #(
    parameter int WORD_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        flag_s,
    input logic        st_empty,
    input logic        st_full,
    input logic        ovf_q,
    input logic        wb_cyc,
    input logic        wb_stb,
    input logic        wb_we,
    input logic [1:0]  wb_adr,
    input logic [31:0] wb_dat_i,
    input logic [31:0] wb_dat_o,
    input logic        wb_ack
);
    localparam int EC_W = $clog2(WORD_W + 2);

    logic [EC_W-1:0] edges_q;
    logic            sclk_d;
    logic            clr_req;
    logic            empty_rd;

    // Count rising SCLK edges inside each chip-select window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_d <= spi_sclk;
            if (spi_cs_n)                 edges_q <= '0;
            else if (spi_sclk && !sclk_d) edges_q <= edges_q + 1'b1;
        end
    end

    assign clr_req  = wb_cyc && wb_stb && !wb_ack && wb_we && wb_adr == 2'd1 && wb_dat_i[2];
    assign empty_rd = wb_cyc && wb_stb && !wb_ack && !wb_we && wb_adr == 2'd0 && st_empty;

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R2
    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edges_q == EC_W'(WORD_W))); // R2
    AST_START_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(flag_s)); // R1
    AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_empty && st_full)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_req) |=> ovf_q); // R6
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack); // R9
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> (wb_ack && wb_dat_o == 32'd0)); // R8
endmodule

bind evt_adc_capture evcap_checker #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .flag_s(flag_s), .st_empty(st_empty), .st_full(st_full), .ovf_q(ovf_q),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack)
);

// File: tb/evt_adc_capture_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: ADC model with random event spacing of at least
// 1 us, and sweeps over order, fill, overflow, empty reads and re-arming.
module evt_adc_capture_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_evt = 1'b0;
    logic        spi_sclk, spi_cs_n, spi_miso;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [1:0]  wb_adr = 2'd0;
    logic [31:0] wb_dat_i = 32'd0;
    logic [31:0] wb_dat_o;
    logic        wb_ack;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    int adc_done = 0;
    int cs_falls = 0;
    int rises = 0;
    int last_rises = 0;
    logic [15:0] cur_sample = 16'd0;

    always #2.5 clk = ~clk;

    evt_adc_capture #(.WORD_W(16), .CLK_DIV(2), .FIFO_DEPTH(DEPTH), .USE_FIFO(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .adc_evt(adc_evt), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
        .wb_ack(wb_ack)
    );

    always @(posedge clk) cycle <= cycle + 1;

    // ADC model: bit index counts rising SCLK edges since chip select fell.
    always @(posedge spi_sclk or negedge spi_cs_n) begin
        if (rst_n === 1'b1) begin
            if (!spi_cs_n && spi_sclk) rises = rises + 1;
            else begin rises = 0; cs_falls = cs_falls + 1; end
        end
    end
    assign spi_miso = (rises < 16) ? cur_sample[15 - rises] : 1'b0;

    always @(posedge spi_cs_n) begin
        if (rst_n === 1'b1) begin
            last_rises = rises;
            adc_done = adc_done + 1;
        end
    end

    function automatic logic [15:0] samp(input int k);
        case (k)
            0: samp = 16'h8000;
            1: samp = 16'h0001;
            2: samp = 16'hFFFF;
            3: samp = 16'h0000;
            default: samp = 16'(k * 40503) ^ 16'(k << 3);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wb_read(input logic [1:0] adr, output logic [31:0] data);
        int waits = 0;
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = adr;
        do begin @(negedge clk); waits++; end while (!wb_ack);
        data = wb_dat_o;
        wb_cyc = 1'b0; wb_stb = 1'b0;
        check(waits == 1, "R9 ack latency", 32'(waits), 32'd1);
    endtask

    task automatic wb_write(input logic [1:0] adr, input logic [31:0] data);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = adr; wb_dat_i = data;
        do @(negedge clk); while (!wb_ack);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    endtask

    // One ADC event: raise flag, wait for the read, release, then idle >= 1 us.
    task automatic fire(input int k, input bit hold_long);
        int t0, d0, f0;
        @(negedge clk);
        cur_sample = samp(k);
        d0 = adc_done; f0 = cs_falls; t0 = cycle;
        adc_evt = 1'b1;
        wait (adc_done != d0);
        check(cycle - t0 < 200, "R3 flag-to-done latency", 32'(cycle - t0), 32'd199);
        check(last_rises == 16, "R2 rising edges per frame", 32'(last_rises), 32'd16);
        if (hold_long) repeat (20) @(negedge clk);
        adc_evt = 1'b0;
        repeat (200 + $urandom_range(0, 80)) @(negedge clk);
        check(cs_falls == f0 + 1, "R11 one transfer per flag", 32'(cs_falls - f0), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 idle pins", {30'd0, spi_cs_n, spi_sclk}, 32'd2);
        rst_n = 1'b1;
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R10 R5 status after reset", rd, 32'd1);
        // R8 empty data read
        wb_read(2'd0, rd);
        check(rd == 32'd0, "R8 empty read value", rd, 32'd0);
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R8 status after empty read", rd, 32'd1);
        // R9 write to data register ignored
        wb_write(2'd0, 32'h1234_5678);
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R9 data write ignored", rd, 32'd1);

        // R4 R7 order and content, including edge values
        for (int k = 0; k < 3; k++) fire(k, 1'b0);
        for (int k = 0; k < 3; k++) begin
            wb_read(2'd0, rd);
            check(rd == {16'd0, samp(k)}, "R7 R4 sample order", rd, {16'd0, samp(k)});
        end
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R5 empty after drain", rd, 32'd1);

        // R5 R6 fill, overflow and drop
        for (int k = 3; k < 3 + DEPTH; k++) fire(k, 1'b0);
        wb_read(2'd1, rd);
        check(rd == 32'd2, "R5 full status", rd, 32'd2);
        fire(50, 1'b0);
        fire(51, 1'b0);
        wb_read(2'd1, rd);
        check(rd == 32'd6, "R6 overflow set", rd, 32'd6);
        wb_write(2'd1, 32'd0);
        wb_read(2'd1, rd);
        check(rd == 32'd6, "R6 write of zero keeps overflow", rd, 32'd6);
        for (int k = 3; k < 3 + DEPTH; k++) begin
            wb_read(2'd0, rd);
            check(rd == {16'd0, samp(k)}, "R6 overflow samples dropped", rd, {16'd0, samp(k)});
        end
        wb_read(2'd1, rd);
        check(rd == 32'd5, "R6 overflow stays while empty", rd, 32'd5);
        wb_write(2'd1, 32'd4);
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R6 overflow cleared", rd, 32'd1);

        // R1 R11 long-held flag gives a single sample
        fire(60, 1'b1);
        wb_read(2'd0, rd);
        check(rd == {16'd0, samp(60)}, "R1 held flag sample", rd, {16'd0, samp(60)});
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R11 no second sample", rd, 32'd1);

        // R4 R7 streaming sweep, two events then two reads
        for (int k = 8; k < 40; k += 2) begin
            fire(k, 1'b0);
            fire(k + 1, k[2]);
            for (int j = 0; j < 2; j++) begin
                wb_read(2'd0, rd);
                check(rd == {16'd0, samp(k + j)}, "R7 streaming order", rd, {16'd0, samp(k + j)});
            end
        end
        wb_read(2'd1, rd);
        check(rd == 32'd1, "R5 final status", rd, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule